// File: doc/BRIEF.md
# Periodic Wakeup Auto-Reload Timer

This block raises a periodic wakeup event inside a real-time-clock domain. A down-counter is loaded with a programmed period and decrements once per time-base tick. When it expires it sets a sticky wakeup flag and reloads itself, so the flag is raised again every period for as long as the timer is enabled. Software clears the flag with a one-cycle clear input.

Two time bases are available. The slow one is the calendar strobe. A two-stage prescaler makes it from the RTC clock: a 7-bit first stage feeds a 15-bit second stage. The fast one divides the raw RTC clock by 2, 4, 8 or 16 and is meant for short timeouts. The period register is 16 bits wide and has one extra range bit, so a period can reach 2^17 ticks. The calendar strobe is also brought out so that a calendar can use it.

Top module: `wkup_timer_top`

## Requirements
- R1: `cal_tick` is a one-cycle strobe that repeats every (async_div+1)×(sync_div+1) clock cycles when both divider values are held constant.
- R2: With `clk_sel[2]`=0 the counter time base is the raw clock divided by 2^(clk_sel[1:0]+1). The codes 0, 1, 2 and 3 give divide-by-2, 4, 8 and 16.
- R3: With `clk_sel[2]`=1 the counter time base is the `cal_tick` strobe.
- R4: While enabled, the flag is set once every N+1 ticks, where N = {reload_ext, reload} is a 17-bit value and `reload_ext` is its most significant bit.
- R5: `wk_flag` stays at 1 until `wk_clr` is high at a clock edge and then reads 0 from the next cycle. An expiry in the same cycle as a clear wins, and the flag stays set.
- R6: While `wk_en` is 0 the counter does not run and the flag is never set.
- R7: After `wk_en` rises, the first expiry comes after N+1 ticks of the selected time base, counted from the enable.
- R8: During reset `wk_flag` and `cal_tick` are 0.
- R9: With N = 0 the flag is set on every tick of the selected time base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RTC clock |
| rst | input | 1 | Synchronous active-high reset |
| async_div | input | 7 | First prescaler stage divide value minus one |
| sync_div | input | 15 | Second prescaler stage divide value minus one |
| wk_en | input | 1 | Timer enable |
| clk_sel | input | 3 | Bit 2 selects the slow tick; bits 1:0 select the fast divider code |
| reload | input | 16 | Low 16 bits of the period value |
| reload_ext | input | 1 | Range extension bit (bit 16 of the period value) |
| wk_clr | input | 1 | Flag clear strobe |
| wk_flag | output | 1 | Sticky wakeup flag |
| cal_tick | output | 1 | Calendar strobe from the two-stage prescaler |

## Verification
A wrong count state shows up as a wrong spacing between two flag rises, and the error appears within one period. The bench therefore measures the cycle distance between consecutive expiries and compares it with the period computed from the settings. Prescaler faults show up as a wrong strobe spacing within one strobe period. A reload missing on disable shows up as a short first period after enable. A wrong extension bit can only be seen after about 2^16 ticks, so one long directed run covers it.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int FAST_STAGES = 4;
  localparam int FAST_SEL_W  = $clog2(FAST_STAGES);

  typedef enum logic {
    SRC_FAST = 1'b0,
    SRC_SLOW = 1'b1
  } wk_src_e;

  typedef struct packed {
    wk_src_e                src;
    logic [FAST_SEL_W-1:0]  div;
  } wk_sel_t;
endpackage

// File: rtl/wkup_prescaler.sv
module wkup_prescaler #(
  parameter int ASYNC_W = 7,
  parameter int SYNC_W  = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ASYNC_W-1:0] async_div,
  input  logic [SYNC_W-1:0]  sync_div,
  output logic               tick_o
);
  logic [ASYNC_W-1:0] a_cnt;
  logic [SYNC_W-1:0]  s_cnt;
  logic               a_zero;
  logic               s_zero;

  assign a_zero = (a_cnt == '0);
  assign s_zero = (s_cnt == '0);

  // First stage divides by async_div+1, second stage counts its pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      a_cnt  <= '0;
      s_cnt  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= a_zero && s_zero;
      if (a_zero) begin
        a_cnt <= async_div;
        if (s_zero) s_cnt <= sync_div;
        else        s_cnt <= s_cnt - 1'b1;
      end else begin
        a_cnt <= a_cnt - 1'b1;
      end
    end
  end

  // R1
  slow_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && $stable(async_div) && async_div != '0) |=> !tick_o);
endmodule

// File: rtl/wkup_fastdiv.sv
module wkup_fastdiv #(
  parameter int STAGES = 4,
  parameter int SEL_W  = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick_o
);
  logic [STAGES-1:0] ph;
  logic [STAGES-1:0] mask_tab [STAGES];

  // One mask per divider code: the low code+1 bits of the phase counter
  for (genvar g = 0; g < STAGES; g++) begin : g_mask
    assign mask_tab[g] = STAGES'((1 << (g + 1)) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      tick_o <= 1'b0;
    end else begin
      ph     <= ph + 1'b1;
      tick_o <= &(ph | ~mask_tab[div_sel]);
    end
  end

  // R2
  fast_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wkup_counter.sv
module wkup_counter #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] period,
  input  logic          clr,
  output logic          flag
);
  logic [CW-1:0] cnt;
  logic          expire;

  assign expire = en && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!en) begin
      cnt <= period;
    end else if (tick) begin
      cnt <= (cnt == '0) ? period : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (expire) flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !(en && tick)) |=> !flag);
  // R6
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !$rose(flag));
  // R4
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(tick));
endmodule

// File: rtl/wkup_timer_top.sv
module wkup_timer_top #(
  parameter int ASYNC_W = 7,
  parameter int SYNC_W  = 15,
  parameter int CNT_W   = 16,
  parameter int EXT_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ASYNC_W-1:0] async_div,
  input  logic [SYNC_W-1:0]  sync_div,
  input  logic               wk_en,
  input  logic [2:0]         clk_sel,
  input  logic [CNT_W-1:0]   reload,
  input  logic [EXT_W-1:0]   reload_ext,
  input  logic               wk_clr,
  output logic               wk_flag,
  output logic               cal_tick
);
  import wkup_pkg::*;

  localparam int CW = CNT_W + EXT_W;

  wk_sel_t       sel;
  logic          fast_tick;
  logic          slow_tick;
  logic          base_tick;
  logic [CW-1:0] period;

  assign sel      = wk_sel_t'(clk_sel);
  assign period   = {reload_ext, reload};
  assign cal_tick = slow_tick;

  wkup_prescaler #(.ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W)) u_pre (
    .clk(clk), .rst(rst), .async_div(async_div), .sync_div(sync_div),
    .tick_o(slow_tick)
  );

  wkup_fastdiv #(.STAGES(FAST_STAGES), .SEL_W(FAST_SEL_W)) u_fast (
    .clk(clk), .rst(rst), .div_sel(sel.div), .tick_o(fast_tick)
  );

  // R3: source select between calendar strobe and fast divider
  assign base_tick = (sel.src == SRC_SLOW) ? slow_tick : fast_tick;

  wkup_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(wk_en), .tick(base_tick), .period(period),
    .clr(wk_clr), .flag(wk_flag)
  );

  // R8
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!wk_flag && !cal_tick));
endmodule

// File: tb/wkup_timer_top_tb_top.sv
module wkup_timer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  async_div = '0;
  logic [14:0] sync_div = '0;
  logic        wk_en = 1'b0;
  logic [2:0]  clk_sel = '0;
  logic [15:0] reload = '0;
  logic        reload_ext = 1'b0;
  logic        wk_clr = 1'b0;
  logic        wk_flag;
  logic        cal_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wkup_timer_top dut_i (
    .clk(clk), .rst(rst), .async_div(async_div), .sync_div(sync_div),
    .wk_en(wk_en), .clk_sel(clk_sel), .reload(reload), .reload_ext(reload_ext),
    .wk_clr(wk_clr), .wk_flag(wk_flag), .cal_tick(cal_tick)
  );

  function automatic int fast_period(int code);
    return 1 << (code + 1);
  endfunction

  function automatic int slow_period(int a, int s);
    return (a + 1) * (s + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_sig(bit use_cal, int limit, output int t);
    t = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((use_cal ? cal_tick : wk_flag) === 1'b1) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic clr_pulse();
    wk_clr = 1'b1;
    @(negedge clk);
    wk_clr = 1'b0;
  endtask

  task automatic restart();
    wk_en = 1'b0;
    clr_pulse();
    @(negedge clk);
    wk_en = 1'b1;
  endtask

  task automatic measure_flag(int exp, string req);
    int t0, t1;
    wait_sig(1'b0, 4 * exp + 64, t0);
    clr_pulse();
    wait_sig(1'b0, 4 * exp + 64, t1);
    chk(t0 >= 0 && t1 >= 0 && (t1 - t0) == exp, req, t1 - t0, exp);
    clr_pulse();
  endtask

  task automatic measure_cal(int exp);
    int t0, t1;
    wait_sig(1'b1, 4 * exp + 64, t0);
    wait_sig(1'b1, 4 * exp + 64, t1);
    chk(t0 >= 0 && t1 >= 0 && (t1 - t0) == exp, "R1", t1 - t0, exp);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int a, s, r, k, te, t;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(wk_flag == 1'b0, "R8", wk_flag, 0);
    chk(cal_tick == 1'b0, "R8", cal_tick, 0);
    rst = 1'b0;

    // R1: directed prescaler periods
    async_div = 7'd3; sync_div = 15'd2;
    measure_cal(slow_period(3, 2));
    async_div = 7'd0; sync_div = 15'd0;
    measure_cal(1);
    async_div = 7'd0; sync_div = 15'd5;
    measure_cal(slow_period(0, 5));

    // R2: every fast divider code, fixed period value
    for (int c = 0; c < 4; c++) begin
      clk_sel = {1'b0, 2'(c)};
      reload = 16'd3; reload_ext = 1'b0;
      restart();
      measure_flag(4 * fast_period(c), "R2");
    end

    // R9: zero period at divide-by-2 and slow source
    clk_sel = 3'b000; reload = '0;
    restart();
    measure_flag(2, "R9");
    async_div = 7'd1; sync_div = 15'd1; clk_sel = 3'b100;
    restart();
    measure_flag(slow_period(1, 1), "R9");

    // R3 / R4: random trials
    for (int i = 0; i < 8; i++) begin
      r = int'($urandom_range(0, 7));
      reload = 16'(r); reload_ext = 1'b0;
      if (i % 2 == 0) begin
        k = int'($urandom_range(0, 3));
        clk_sel = {1'b0, 2'(k)};
        restart();
        measure_flag((r + 1) * fast_period(k), "R4");
      end else begin
        a = int'($urandom_range(0, 3));
        s = int'($urandom_range(0, 3));
        async_div = 7'(a); sync_div = 15'(s);
        clk_sel = 3'b100;
        restart();
        measure_flag((r + 1) * slow_period(a, s), "R3");
      end
    end

    // R5: sticky flag, then set wins over a held clear
    clk_sel = 3'b000; reload = 16'd4;
    restart();
    wait_sig(1'b0, 64, t);
    repeat (30) @(negedge clk);
    chk(wk_flag == 1'b1, "R5", wk_flag, 1);
    clr_pulse();
    chk(wk_flag == 1'b0, "R5", wk_flag, 0);
    reload = '0;
    restart();
    wk_clr = 1'b1;
    wait_sig(1'b0, 8, t);
    chk(t >= 0, "R5", t, 1);
    wk_clr = 1'b0;

    // R6: disabled timer raises nothing
    wk_en = 1'b0;
    clr_pulse();
    repeat (300) @(negedge clk);
    chk(wk_flag == 1'b0, "R6", wk_flag, 0);

    // R7: full period after enable
    reload = 16'd9; clk_sel = 3'b000;
    @(negedge clk);
    wk_en = 1'b1; te = cyc;
    wait_sig(1'b0, 100, t);
    chk(t - te >= 19 && t - te <= 20, "R7", t - te, 20);
    clr_pulse();

    // R4: range extension bit, period 65537 ticks at divide-by-2
    wk_en = 1'b0; reload = '0; reload_ext = 1'b1;
    clr_pulse();
    @(negedge clk);
    wk_en = 1'b1; te = cyc;
    repeat (131060) @(negedge clk);
    chk(wk_flag == 1'b0, "R4", wk_flag, 0);
    wait_sig(1'b0, 40, t);
    chk(t - te >= 131073 && t - te <= 131075, "R4", t - te, 131074);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule